// File: doc/BRIEF.md
# Logic Unit with Shifted Second Operand

This block is the bitwise slice of an integer execution pipeline. Each cycle it may accept one operation on two data words. The second word can come straight from an immediate, or it can be a register value that first passes through a barrel shifter. The shifter moves the value left or right, or rotates it, by a 6-bit amount. After the shifter, the unit performs AND, AND with flag update, AND-with-complement (bit clear), OR, or a bitwise inversion of the second operand.

The result and a one-cycle valid pulse leave the block through registers, one clock after the request. The four condition flags (negative, zero, carry, overflow) are also held in a register. Only the flag-setting AND writes to them; every other request leaves them alone. Instruction decode, immediate-encoding legality and the register file belong to the surrounding pipeline.

Top module: `lu_unit`

## Requirements
- R1: Opcode 0 gives A AND B', opcode 2 gives A AND NOT B', and opcode 3 gives A OR B', where B' is the second operand after the shifter (or the immediate).
- R2: Opcode 1 gives the same result as opcode 0. It also loads the flags `out_flags` = {N,Z,C,V} (bit 3 down to bit 0) with N = result bit 63, Z = 1 exactly when the result is zero, and C = V = 0.
- R3: Opcodes other than 1, and cycles with no valid request, leave `out_flags` unchanged.
- R4: Shift kind 0 (logical left) moves B left by the amount and fills the vacated low bits with zeros.
- R5: Shift kind 1 (logical right) moves B right and fills the vacated high bits with zeros.
- R6: Shift kind 2 (arithmetic right) moves B right and fills the vacated high bits with copies of the original bit 63.
- R7: Shift kind 3 (rotate right) moves B right and feeds the bits that leave the low end back in at the high end.
- R8: A shift amount of 0 passes B through unchanged for every shift kind.
- R9: When `in_use_imm` is 1, B is used as given, and the shift kind and amount have no effect.
- R10: Opcode 4 gives NOT B'. The shift applies to B, and A has no effect.
- R11: The result appears one cycle after an accepted request, and `out_valid` is high for exactly that cycle. `out_result` holds its value through cycles with no request.
- R12: During reset, `out_valid`, `out_result` and `out_flags` are all zero.
- R13: Reserved opcodes 5 to 7 give a zero result and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Opcode (0 AND, 1 AND+flags, 2 bit clear, 3 OR, 4 NOT) |
| in_use_imm | input | 1 | 1: B is an immediate and bypasses the shifter |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand (register value or immediate) |
| in_kind | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| in_amt | input | 6 | Shift amount, 0 to 63 |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 64 | Registered result |
| out_flags | output | 4 | Condition flags {N,Z,C,V} |

## Verification
The bench sweeps every shift amount against every shift kind and every opcode, using operands with the top bit both set and clear. This exposes three kinds of fault. The first is a fill that comes from the wrong end: an arithmetic shift that fills with zeros, or a rotate that drops bits. The second is an off-by-one stage in the barrel shifter, which shows up only at particular amounts. The third is a zero amount that corrupts the rotate path. Flag checks follow every request. A unit that let OR, bit clear, NOT or a reserved opcode write the flags, or that computed Z from the wrong operand, would be caught at once. Immediate requests carry nonzero shift fields, and NOT requests carry arbitrary A values. This shows whether either field leaks into the result.

// File: rtl/lu_pkg.sv
package lu_pkg;

   typedef enum logic [2:0] {
      LOP_AND  = 3'd0,
      LOP_ANDS = 3'd1,
      LOP_BIC  = 3'd2,
      LOP_ORR  = 3'd3,
      LOP_NOT  = 3'd4
   } lop_e;

   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } skind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cflags_t;

endpackage

// File: rtl/lu_shifter.sv
module lu_shifter #(
   parameter int W      = 64,
   parameter bit STAGED = 1'b1,
   localparam int AW    = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [1:0]    kind,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   import lu_pkg::*;

   generate
      if (STAGED) begin : g_staged
         // log2(W) mux stages, stage i moves by 2**i
         logic [AW:0][W-1:0] stg;
         assign stg[0] = din;
         for (genvar i = 0; i < AW; i++) begin : g_stage
            localparam int S = 1 << i;
            logic [W-1:0] moved;
            always_comb begin
               unique case (skind_e'(kind))
                  SK_LSL:  moved = stg[i] << S;
                  SK_LSR:  moved = stg[i] >> S;
                  SK_ASR:  moved = W'($signed(stg[i]) >>> S);
                  default: moved = (stg[i] >> S) | (stg[i] << (W - S));
               endcase
            end
            assign stg[i+1] = amt[i] ? moved : stg[i];
         end
         assign dout = stg[AW];
      end else begin : g_flat
         logic [AW:0] back;
         assign back = (AW+1)'(W) - {1'b0, amt};
         always_comb begin
            unique case (skind_e'(kind))
               SK_LSL:  dout = din << amt;
               SK_LSR:  dout = din >> amt;
               SK_ASR:  dout = W'($signed(din) >>> amt);
               default: dout = (din >> amt) | (din << back);
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/lu_logic.sv
module lu_logic #(
   parameter int W = 64
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         flag_wr
);
   import lu_pkg::*;

   always_comb begin
      flag_wr = 1'b0;
      case (lop_e'(op))
         LOP_AND:  res = a & b;
         LOP_ANDS: begin
            res     = a & b;
            flag_wr = 1'b1;
         end
         LOP_BIC:  res = a & ~b;
         LOP_ORR:  res = a | b;
         LOP_NOT:  res = ~b;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/lu_unit.sv
module lu_unit #(
   parameter int DATA_W       = 64,
   parameter bit STAGED_SHIFT = 1'b1,
   localparam int AMT_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic              in_use_imm,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [1:0]        in_kind,
   input  logic [AMT_W-1:0]  in_amt,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic [3:0]        out_flags
);
   import lu_pkg::*;

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("lu_unit: DATA_W must be a power of two of at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] b_shifted, b_eff, res;
   logic              flag_wr;
   cflags_t           flags_q;

   lu_shifter #(.W(DATA_W), .STAGED(STAGED_SHIFT)) i_shift (
      .din  (in_b),
      .kind (in_kind),
      .amt  (in_amt),
      .dout (b_shifted)
   );

   assign b_eff = in_use_imm ? in_b : b_shifted;

   lu_logic #(.W(DATA_W)) i_logic (
      .op      (in_op),
      .a       (in_a),
      .b       (b_eff),
      .res     (res),
      .flag_wr (flag_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         flags_q    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= res;
            if (flag_wr) begin
               flags_q.n <= res[DATA_W-1];
               flags_q.z <= ~|res;
               flags_q.c <= 1'b0;
               flags_q.v <= 1'b0;
            end
         end
      end
   end

   assign out_flags = flags_q;

endmodule

// File: rtl/lu_checker.sv
module lu_checker #(
   parameter int W = 64
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [2:0]   in_op,
   input logic         in_use_imm,
   input logic [W-1:0] in_a,
   input logic [W-1:0] in_b,
   input logic         out_valid,
   input logic [W-1:0] out_result,
   input logic [3:0]   out_flags
);

   p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 out_valid == $past(in_valid));

   p_result_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));

   p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_op == 3'd1) |=> $stable(out_flags));

   p_flags_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd1) |=>
         (out_flags[3] == out_result[W-1]) &&
         (out_flags[2] == (out_result == '0)) &&
         (out_flags[1:0] == 2'b00));

   p_imm_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_use_imm && in_op == 3'd3) |=>
         out_result == ($past(in_a) | $past(in_b)));

   p_reserved_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op > 3'd4) |=> out_result == '0);

endmodule

bind lu_unit lu_checker #(.W(DATA_W)) i_lu_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_op      (in_op),
   .in_use_imm (in_use_imm),
   .in_a       (in_a),
   .in_b       (in_b),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_flags  (out_flags)
);

// File: tb/test_lu_unit.sv
module test_lu_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic        in_use_imm = 1'b0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic [1:0]  in_kind = '0;
   logic [5:0]  in_amt = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic [3:0]  out_flags;

   int checks = 0;
   int fails  = 0;
   logic [3:0] exp_flags = 4'b0000;

   always #5 clk = ~clk;

   lu_unit i_lu_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_use_imm(in_use_imm), .in_a(in_a), .in_b(in_b), .in_kind(in_kind),
      .in_amt(in_amt), .out_valid(out_valid), .out_result(out_result),
      .out_flags(out_flags)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // bit-by-bit model of the four shift kinds
   function automatic logic [63:0] ref_shift(input logic [63:0] x, input logic [1:0] k,
                                             input int s);
      logic [63:0] r;
      for (int j = 0; j < 64; j++) begin
         case (k)
            2'd0: r[j] = (j >= s) ? x[j-s] : 1'b0;
            2'd1: r[j] = (j + s < 64) ? x[j+s] : 1'b0;
            2'd2: r[j] = (j + s < 64) ? x[j+s] : x[63];
            default: r[j] = x[(j + s) % 64];
         endcase
      end
      return r;
   endfunction

   function automatic string tag_for(input logic [2:0] op, input bit imm,
                                     input logic [1:0] k, input int s);
      if (op > 3'd4)  return "R13";
      if (imm)        return "R9";
      if (s == 0)     return "R8";
      if (op == 3'd4) return "R10";
      if (op == 3'd1) return "R2";
      case (k)
         2'd0: return "R4";
         2'd1: return "R5";
         2'd2: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic run(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                      input bit imm, input logic [1:0] k, input int s);
      logic [63:0] bb, r;
      string tg;
      bb = imm ? b : ref_shift(b, k, s);
      case (op)
         3'd0, 3'd1: r = a & bb;
         3'd2:       r = a & ~bb;
         3'd3:       r = a | bb;
         3'd4:       r = ~bb;
         default:    r = 64'd0;
      endcase
      if (op == 3'd1) exp_flags = {r[63], r == 64'd0, 2'b00};
      tg = tag_for(op, imm, k, s);
      if (op == 3'd0 || op == 3'd2 || op == 3'd3) tg = {tg, "/R1"};
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
      in_use_imm = imm; in_kind = k; in_amt = 6'(s);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1, "R11 valid", 64'(out_valid), 64'd1);
      check(out_result === r, tg, out_result, r);
      check(out_flags === exp_flags, (op == 3'd1) ? "R2 flags" : "R3 flags",
            64'(out_flags), 64'(exp_flags));
   endtask

   logic [63:0] pa [4];
   logic [63:0] pb [4];

   initial begin
      pa[0] = 64'hFFFF_0000_FFFF_0000; pb[0] = 64'h8000_0000_0000_0001;
      pa[1] = 64'hFFFF_FFFF_FFFF_FFFF; pb[1] = 64'hF0E1_D2C3_B4A5_9687;
      pa[2] = 64'h0F0F_3C3C_A5A5_5A5A; pb[2] = 64'h0123_4567_89AB_CDEF;
      pa[3] = 64'h0000_0000_0000_0000; pb[3] = 64'hDEAD_BEEF_0BAD_F00D;

      repeat (3) @(negedge clk);
      // R12: reset state
      check(out_valid === 1'b0, "R12 valid", 64'(out_valid), 64'd0);
      check(out_result === 64'd0, "R12 result", out_result, 64'd0);
      check(out_flags === 4'd0, "R12 flags", 64'(out_flags), 64'd0);
      rst_n = 1'b1;

      // sweep: patterns x kinds x amounts x opcodes
      for (int p = 0; p < 4; p++)
         for (int k = 0; k < 4; k++)
            for (int s = 0; s < 64; s++)
               for (int op = 0; op < 5; op++)
                  run(3'(op), pa[p], pb[p], 1'b0, 2'(k), s);

      // R2: zero result sets Z, top bit sets N
      run(3'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 0);
      check(out_flags === 4'b0100, "R2 Z set", 64'(out_flags), 64'h4);
      run(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, 2'd3, 0);
      check(out_flags === 4'b1000, "R2 N set", 64'(out_flags), 64'h8);

      // R9: immediate ignores shift fields
      for (int op = 0; op < 5; op++)
         for (int k = 0; k < 4; k++)
            run(3'(op), pa[2], pb[2], 1'b1, 2'(k), 13 + k);

      // R10: NOT ignores A
      run(3'd4, 64'h0, pb[1], 1'b0, 2'd2, 7);
      run(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, pb[1], 1'b0, 2'd2, 7);

      // R13: reserved opcodes after a flag-setting op
      run(3'd1, pa[1], pb[0], 1'b0, 2'd0, 0);
      for (int op = 5; op < 8; op++) run(3'(op), pa[1], pb[1], 1'b0, 2'(op), 3);

      // R11: idle cycles keep the result and drop valid
      run(3'd3, pa[2], pb[3], 1'b0, 2'd1, 5);
      begin
         logic [63:0] held;
         held = out_result;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R11 idle valid", 64'(out_valid), 64'd0);
            check(out_result === held, "R11 hold", out_result, held);
            check(out_flags === exp_flags, "R3 idle flags", 64'(out_flags), 64'(exp_flags));
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule